// File: doc/BRIEF.md
# Guarded nonvolatile write controller

This block stands between a processor's register interface and a byte-wide nonvolatile data array. It releases a write to the array only after a deliberate ritual. Software first sets an enable bit. It then writes 55h and then AAh to a dedicated key register in back-to-back accesses. Finally it sets a start bit in the control register. The start bit then reads as a busy flag for a fixed number of cycles, and it drops when the modelled array write commits, so software can poll it. Writes are also held off while the power-up timer runs.

A second, external programming port gives direct byte reads and writes of the same array. A code-protect input shuts that port out, while the processor's own reads and writes continue to work. A sticky error flag records that a warm reset cut a write short. That flag survives the warm reset and is cleared only by power-on reset or by software.

The register interface selects one of four registers with a 2-bit select. Select 0 is control, 1 is address, 2 is data and 3 is key. The control byte has these bits: bit 0 is the read strobe (reads 0), bit 1 is start/busy, bit 2 is write enable, and bit 3 is the write-error flag, which is cleared by writing 1. A control write loads bit 2 from the written byte.

Top module: `nvw_guard_ctrl`

## Requirements
- R1: After reset the control register reads 00h: write enable clear, busy clear, no error (after power-on reset).
- R2: Writing 55h then AAh to the key register (select 3) in consecutive accesses, then writing the control register with bits 1 and 2 set while enable is already set, starts a write. Busy (control bit 1) then reads 1 for exactly WR_CYCLES cycles, and the byte from the data register lands at the address register's location.
- R3: A key write of any value other than the expected next key returns the unlock sequence to idle. A later start is then ignored: busy stays 0 and the array is unchanged.
- R4: Any other register read or write between the two key writes, or between the second key write and the start, cancels the unlock, and the start is ignored.
- R5: A start request while write enable is clear is ignored, even after a correct key sequence.
- R6: A start request while pwrt_active is high is ignored.
- R7: Address and data are captured when a write starts. Changing the address or data register while busy does not change which byte is written or where it goes.
- R8: Writing control bit 0 loads the data register with the array byte at the current address at that clock edge.
- R9: While code_protect is high, external port accesses are refused: ext_ok is 0, ext_rdata is 0 and the array is not written. Internal writes and reads still work.
- R10: With code_protect low and no write in progress, an external access is answered one cycle later with ext_ok 1. A read also returns the addressed byte on ext_rdata, and a write stores ext_wdata.
- R11: Asserting rst_n low while busy aborts the write (the array is unchanged) and sets control bit 3. Bit 3 survives rst_n and is cleared by writing 1 to it.
- R12: External accesses are refused (ext_ok 0) while an internal write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the error flag |
| rst_n | input | 1 | Warm reset, active low, synchronous |
| pwrt_active | input | 1 | Power-up timer running; blocks write starts |
| code_protect | input | 1 | Refuses external port accesses when high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 key |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| ext_valid | input | 1 | External port request |
| ext_we | input | 1 | External request is a write |
| ext_addr | input | ADDR_W | External byte address |
| ext_wdata | input | 8 | External write data |
| ext_ok | output | 1 | External request accepted (one cycle after request) |
| ext_rdata | output | 8 | External read data (0 when refused or on writes) |

## Verification
The bench targets the unlock sequence's fragility. It tries a wrong second key, the keys in reversed order, and a stray register access between the keys or just before the start. A controller that only remembered having seen both keys at some point would start a write in each case, and the busy flag would rise. It also changes the address and data registers in the middle of a write: a design that did not capture them at start would write the new byte to the new address. A warm reset during a write is checked for both an aborted commit and a surviving error flag. A design that committed early, or cleared the flag with warm reset, would show the new byte or a clean control register. Code protect is checked in both directions, so that a design which also blocked the processor, or let the port through, fails.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
    // Register select codes
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_KEY  = 2'd3;

    // Control byte bit positions
    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_EN  = 2;
    localparam int CB_ERR = 3;

    // Unlock key values, in required order
    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_GOT1  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        unlock_e st;
    } unlock_st;
endpackage

// File: rtl/nvw_unlock.sv
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    input  logic       other_acc,
    output logic       armed
);
    unlock_st q, d;

    always_comb begin
        d = q;
        if (key_wr) begin
            if (key_val == KEY_FIRST) begin
                d.st = UL_GOT1;
            end else if (key_val == KEY_SECOND && q.st == UL_GOT1) begin
                d.st = UL_ARMED;
            end else begin
                d.st = UL_IDLE;
            end
        end else if (other_acc) begin
            // any non-key access breaks (or consumes) the sequence
            d.st = UL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= UL_IDLE;
        end else begin
            q <= d;
        end
    end

    assign armed = (q.st == UL_ARMED);
endmodule

// File: rtl/nvw_wr_timer.sv
module nvw_wr_timer #(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    output logic              busy,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [7:0]        commit_data
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } tmr_st;

    tmr_st q, d;
    logic  last;

    assign last = q.busy && (q.cnt == CNT_W'(1));

    always_comb begin
        d = q;
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(WR_CYCLES);
            d.addr = start_addr;
            d.data = start_data;
        end else if (q.busy) begin
            d.cnt = q.cnt - CNT_W'(1);
            if (last) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = q.busy;
    assign commit      = last;
    assign commit_addr = q.addr;
    assign commit_data = q.data;
endmodule

// File: rtl/nvw_array.sv
module nvw_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/nvw_guard_ctrl.sv
module nvw_guard_ctrl
    import nvw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              pwrt_active,
    input  logic              code_protect,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ext_valid,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [7:0]        ext_wdata,
    output logic              ext_ok,
    output logic [7:0]        ext_rdata
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              ext_ok;
        logic [7:0]        ext_rdata;
    } ctl_st;

    ctl_st q, d;
    logic  err_q, err_d;

    logic              ctrl_wr, key_wr, other_acc;
    logic              unlock_armed, wr_busy, wr_start;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [7:0]        commit_data;
    logic              ext_go;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [7:0]        cpu_byte, ext_byte;
    logic              wr_en_q;

    assign ctrl_wr   = reg_we && (reg_sel == SEL_CTRL);
    assign key_wr    = reg_we && (reg_sel == SEL_KEY);
    assign other_acc = (reg_we && (reg_sel != SEL_KEY)) || reg_re;
    assign wr_en_q   = q.en;

    nvw_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_val   (reg_wdata),
        .other_acc (other_acc),
        .armed     (unlock_armed)
    );

    assign wr_start = ctrl_wr && reg_wdata[CB_WR] && unlock_armed &&
                      q.en && !pwrt_active && !wr_busy;

    nvw_wr_timer #(
        .ADDR_W    (ADDR_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (wr_start),
        .start_addr  (q.addr),
        .start_data  (q.data),
        .busy        (wr_busy),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    assign ext_go    = ext_valid && !code_protect && !wr_busy;
    assign arr_we    = commit || (ext_go && ext_we);
    assign arr_waddr = commit ? commit_addr : ext_addr;
    assign arr_wdata = commit ? commit_data : ext_wdata;

    nvw_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr_a (q.addr),
        .rdata_a (cpu_byte),
        .raddr_b (ext_addr),
        .rdata_b (ext_byte)
    );

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.en = reg_wdata[CB_EN];
            if (reg_wdata[CB_RD]) begin
                d.data = cpu_byte;
            end
        end
        if (reg_we && reg_sel == SEL_ADDR) begin
            d.addr = reg_wdata[ADDR_W-1:0];
        end
        if (reg_we && reg_sel == SEL_DATA) begin
            d.data = reg_wdata;
        end
        d.ext_ok    = ext_go;
        d.ext_rdata = (ext_go && !ext_we) ? ext_byte : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Error flag lives in the power-on domain so a warm reset can set it
    always_comb begin
        err_d = err_q;
        if (!rst_n) begin
            if (wr_busy) begin
                err_d = 1'b1;
            end
        end else if (ctrl_wr && reg_wdata[CB_ERR]) begin
            err_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {4'b0000, err_q, q.en, wr_busy, 1'b0};
            SEL_ADDR: reg_rdata = 8'(q.addr);
            SEL_DATA: reg_rdata = q.data;
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign ext_ok    = q.ext_ok;
    assign ext_rdata = q.ext_rdata;
endmodule

// File: rtl/nvw_guard_chk.sv
module nvw_guard_chk #(
    parameter int WR_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic pwrt_active,
    input logic code_protect,
    input logic ext_valid,
    input logic ext_ok,
    input logic wr_busy,
    input logic unlock_armed,
    input logic wr_en_q
);
    localparam int CNT_W = $clog2(WR_CYCLES + 2);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (wr_busy) begin
            busy_cnt <= busy_cnt + CNT_W'(1);
        end else begin
            busy_cnt <= '0;
        end
    end

    AST_EN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !wr_en_q); // R1

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_busy) && $past(rst_n)) |-> (busy_cnt == CNT_W'(WR_CYCLES))); // R2

    AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(unlock_armed)); // R3

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(wr_en_q)); // R5

    AST_START_NOT_IN_PWRT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(!pwrt_active)); // R6

    AST_EXT_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && code_protect) |=> !ext_ok); // R9

    AST_EXT_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && wr_busy) |=> !ext_ok); // R12
endmodule

bind nvw_guard_ctrl nvw_guard_chk #(
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwrt_active  (pwrt_active),
    .code_protect (code_protect),
    .ext_valid    (ext_valid),
    .ext_ok       (ext_ok),
    .wr_busy      (wr_busy),
    .unlock_armed (unlock_armed),
    .wr_en_q      (wr_en_q)
);

// File: tb/tb_nvw_guard_ctrl.sv
`timescale 1ns/1ps
module tb_nvw_guard_ctrl;
    localparam int ADDR_W    = 8;
    localparam int WR_CYCLES = 16;
    localparam logic [1:0] S_CTRL = 2'd0;
    localparam logic [1:0] S_ADDR = 2'd1;
    localparam logic [1:0] S_DATA = 2'd2;
    localparam logic [1:0] S_KEY  = 2'd3;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwrt_active = 1'b0;
    logic              code_protect = 1'b0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        reg_rdata;
    logic              ext_valid = 1'b0;
    logic              ext_we = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic [7:0]        ext_wdata = 8'h00;
    logic              ext_ok;
    logic [7:0]        ext_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvw_guard_ctrl #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .pwrt_active(pwrt_active),
        .code_protect(code_protect), .reg_we(reg_we), .reg_re(reg_re),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_valid(ext_valid), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_ok(ext_ok), .ext_rdata(ext_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [7:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [7:0] v);
        reg_re = 1'b1; reg_sel = s;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic ext_acc(input logic we, input logic [7:0] a, input logic [7:0] wd,
                           output logic ok, output logic [7:0] rd);
        ext_valid = 1'b1; ext_we = we; ext_addr = a; ext_wdata = wd;
        @(negedge clk);
        ok = ext_ok; rd = ext_rdata;
        ext_valid = 1'b0; ext_we = 1'b0;
    endtask

    task automatic unlock_start();
        reg_wr(S_KEY, 8'h55);
        reg_wr(S_KEY, 8'hAA);
        reg_wr(S_CTRL, 8'h06);
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] v;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            peek(S_CTRL, v);
            if (!v[1]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
        reg_wr(S_ADDR, a);
        reg_wr(S_CTRL, 8'h05);
        peek(S_DATA, v);
    endtask

    task automatic preset(input logic [7:0] a, input logic [7:0] v);
        logic ok; logic [7:0] rd;
        ext_acc(1'b1, a, v, ok, rd);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(S_CTRL, v);
        check("R1", "control after reset", v, 8'h00);
    endtask

    task automatic t_ext_rw();
        logic ok; logic [7:0] rd;
        ext_acc(1'b1, 8'h10, 8'h3C, ok, rd);
        check("R10", "ext write ok", {7'b0, ok}, 8'h01);
        ext_acc(1'b0, 8'h10, 8'h00, ok, rd);
        check("R10", "ext read ok", {7'b0, ok}, 8'h01);
        check("R10", "ext read data", rd, 8'h3C);
    endtask

    task automatic t_good_write();
        logic [7:0] v; int n;
        logic ok; logic [7:0] rd;
        reg_wr(S_ADDR, 8'h20);
        reg_wr(S_DATA, 8'h5A);
        reg_wr(S_CTRL, 8'h04);
        unlock_start();
        wait_idle(n);
        check("R2", "busy cycle count", 8'(n), 8'(WR_CYCLES));
        read_byte(8'h20, v);
        check("R8", "read strobe data", v, 8'h5A);
        @(negedge clk);
        ext_acc(1'b0, 8'h20, 8'h00, ok, rd);
        check("R2", "committed byte via port", rd, 8'h5A);
    endtask

    task automatic t_bad_key();
        logic [7:0] v;
        @(negedge clk);
        preset(8'h21, 8'h00);
        reg_wr(S_ADDR, 8'h21);
        reg_wr(S_DATA, 8'hC3);
        reg_wr(S_CTRL, 8'h04);
        reg_wr(S_KEY, 8'h55);
        reg_wr(S_KEY, 8'h12);
        reg_wr(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        check("R3", "busy after wrong key", {7'b0, v[1]}, 8'h00);
        @(negedge clk);
        reg_wr(S_KEY, 8'hAA);
        reg_wr(S_KEY, 8'h55);
        reg_wr(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        check("R3", "busy after reversed keys", {7'b0, v[1]}, 8'h00);
        @(negedge clk);
        read_byte(8'h21, v);
        check("R3", "array unchanged", v, 8'h00);
    endtask

    task automatic t_intervening();
        logic [7:0] v;
        @(negedge clk);
        reg_wr(S_DATA, 8'h77);
        reg_wr(S_CTRL, 8'h04);
        reg_wr(S_KEY, 8'h55);
        reg_rd(S_ADDR, v);
        reg_wr(S_KEY, 8'hAA);
        reg_wr(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        check("R4", "busy after read between keys", {7'b0, v[1]}, 8'h00);
        @(negedge clk);
        reg_wr(S_KEY, 8'h55);
        reg_wr(S_KEY, 8'hAA);
        reg_wr(S_DATA, 8'h77);
        reg_wr(S_CTRL, 8'h06);
        peek(S_CTRL, v);
        check("R4", "busy after write before start", {7'b0, v[1]}, 8'h00);
    endtask

    task automatic t_no_enable();
        logic [7:0] v;
        @(negedge clk);
        reg_wr(S_CTRL, 8'h00);
        unlock_start();
        peek(S_CTRL, v);
        check("R5", "busy with enable clear", {7'b0, v[1]}, 8'h00);
    endtask

    task automatic t_pwrt();
        logic [7:0] v;
        @(negedge clk);
        pwrt_active = 1'b1;
        reg_wr(S_CTRL, 8'h04);
        unlock_start();
        peek(S_CTRL, v);
        check("R6", "busy during power-up timer", {7'b0, v[1]}, 8'h00);
        pwrt_active = 1'b0;
    endtask

    task automatic t_latch();
        logic [7:0] v; int n;
        logic ok; logic [7:0] rd;
        @(negedge clk);
        preset(8'h30, 8'h00);
        preset(8'h31, 8'h00);
        reg_wr(S_ADDR, 8'h30);
        reg_wr(S_DATA, 8'h11);
        reg_wr(S_CTRL, 8'h04);
        unlock_start();
        reg_wr(S_ADDR, 8'h31);
        reg_wr(S_DATA, 8'h99);
        ext_acc(1'b1, 8'h40, 8'hEE, ok, rd);
        check("R12", "ext refused while busy", {7'b0, ok}, 8'h00);
        wait_idle(n);
        read_byte(8'h30, v);
        check("R7", "latched target byte", v, 8'h11);
        @(negedge clk);
        read_byte(8'h31, v);
        check("R7", "new address untouched", v, 8'h00);
    endtask

    task automatic t_code_protect();
        logic [7:0] v; int n;
        logic ok; logic [7:0] rd;
        @(negedge clk);
        code_protect = 1'b1;
        ext_acc(1'b1, 8'h50, 8'h77, ok, rd);
        check("R9", "protected ext write ok", {7'b0, ok}, 8'h00);
        ext_acc(1'b0, 8'h50, 8'h00, ok, rd);
        check("R9", "protected ext read ok", {7'b0, ok}, 8'h00);
        check("R9", "protected ext read data", rd, 8'h00);
        reg_wr(S_ADDR, 8'h50);
        reg_wr(S_DATA, 8'hE1);
        reg_wr(S_CTRL, 8'h04);
        unlock_start();
        wait_idle(n);
        read_byte(8'h50, v);
        check("R9", "internal write under protect", v, 8'hE1);
        @(negedge clk);
        code_protect = 1'b0;
        ext_acc(1'b0, 8'h50, 8'h00, ok, rd);
        check("R9", "protected write did not land", rd, 8'hE1);
    endtask

    task automatic t_err();
        logic [7:0] v;
        @(negedge clk);
        preset(8'h60, 8'h00);
        reg_wr(S_ADDR, 8'h60);
        reg_wr(S_DATA, 8'hAB);
        reg_wr(S_CTRL, 8'h04);
        unlock_start();
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(S_CTRL, v);
        check("R11", "control after warm reset in write", v, 8'h08);
        @(negedge clk);
        read_byte(8'h60, v);
        check("R11", "aborted write left array", v, 8'h00);
        @(negedge clk);
        reg_wr(S_CTRL, 8'h08);
        peek(S_CTRL, v);
        check("R11", "error cleared by write 1", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ext_rw();
        t_good_write();
        t_bad_key();
        t_intervening();
        t_no_enable();
        t_pwrt();
        t_latch();
        t_code_protect();
        t_err();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule